// File: doc/BRIEF.md
# Serial Port Error Status Aggregator

This block gathers error events from a parameterised number of serial ports and keeps each one in a sticky status bit. Every port reports three kinds of error. The first is a data underflow or overflow on channel A. The second is the same fault on channel B. The third is a frame sync error. A frame sync error comes either from a pulse raised by the port or from a built-in check. That check runs in late frame sync mode and flags a word transfer during which frame sync drops.

Each port has one control register on a simple read/write bus. The register holds an interrupt enable and a sticky status bit for each error kind. Software clears a status bit in either of two ways: it writes a 1 to that bit, or it disables the port or channel that owns the bit. One registered interrupt line serves all ports together. It is high while any enabled sticky bit is set. A read-only summary register returns the status of every port at once, showing each error only while its enable is on.

Top module: `sport_err_hub`

## Requirements
- R1: A single-cycle pulse on `derr_a_pls[k]`, `derr_b_pls[k]` or `fserr_pls[k]` sets the matching sticky bit of port k at the next clock edge.
- R2: A sticky bit stays set until it is cleared by a write of 1 or by a disable. It does not clear because its event input has gone low.
- R3: The register of port k is at address k. Bits [2:0] are the enables for A, B and frame sync and are written directly. Bits [5:3] are the status bits for A, B and frame sync: writing 1 to one of them clears it, and writing 0 leaves it unchanged. All other read bits are 0.
- R4: While `port_en[k]` is low, the frame sync bit of port k is held clear. While `cha_en[k]` is low, only the A bit is held clear. While `chb_en[k]` is low, only the B bit is held clear.
- R5: An event on the same cycle as a clear of the same bit (by a write or by a disable) leaves the bit set.
- R6: `irq` goes high one cycle after any sticky bit with its enable set becomes set. It goes low one cycle after the last such bit clears. A sticky bit whose enable is off never raises `irq`.
- R7: Address NPORT is the summary register. Bit 3k+j reads as 1 only when status bit j of port k is set and enable j of port k is on, with j=0 for A, 1 for B and 2 for frame sync. Writes to this address change nothing. Addresses above NPORT read as 0.
- R8: When `late_fs_mode[k]` and `xfer_busy[k]` are high and `fs_level[k]` is low at a clock edge, the frame sync bit of port k is set. With `late_fs_mode[k]` low, this condition has no effect.
- R9: After reset, every sticky bit and every enable is 0, `irq` is 0, and every address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| port_en | input | NPORT | Per-port enable; low clears the frame sync bit |
| cha_en | input | NPORT | Channel A enable; low clears the A bit |
| chb_en | input | NPORT | Channel B enable; low clears the B bit |
| derr_a_pls | input | NPORT | Channel A data error pulses |
| derr_b_pls | input | NPORT | Channel B data error pulses |
| fserr_pls | input | NPORT | Frame sync error pulses |
| late_fs_mode | input | NPORT | Late frame sync mode select per port |
| xfer_busy | input | NPORT | High while a word transfer is in progress |
| fs_level | input | NPORT | Current frame sync level per port |
| irq | output | 1 | Shared registered error interrupt |

## Verification
The collision of interest is an error event landing on a bit in the same cycle that the bit is cleared. The clear can come from a write of 1 or from dropping the owning channel or port enable. The bench provokes both forms on purpose by driving the pulse and the clear on the same negative edge. It also lets a random phase make such overlaps often. Each time, the bit must read back as set, and `irq` must follow it one cycle later. A behavioural model in the bench applies set-over-clear priority and judges every cycle against it.

// File: rtl/sport_err_hub.sv
module sport_err_hub #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NPORT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPORT-1:0]  port_en,
  input  logic [NPORT-1:0]  cha_en,
  input  logic [NPORT-1:0]  chb_en,
  input  logic [NPORT-1:0]  derr_a_pls,
  input  logic [NPORT-1:0]  derr_b_pls,
  input  logic [NPORT-1:0]  fserr_pls,
  input  logic [NPORT-1:0]  late_fs_mode,
  input  logic [NPORT-1:0]  xfer_busy,
  input  logic [NPORT-1:0]  fs_level,
  output logic              irq
);
  localparam int NB = 3 * NPORT;

  logic [NB-1:0] sticky_q, en_q, evt_vec, clr_vec;

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic sel, late_err;
    assign sel      = wr_en && (wr_addr == ADDR_W'(k));
    assign late_err = late_fs_mode[k] & xfer_busy[k] & ~fs_level[k];
    assign evt_vec[3*k +: 3] = {fserr_pls[k] | late_err, derr_b_pls[k], derr_a_pls[k]};
    assign clr_vec[3*k +: 3] = (sel ? wr_data[5:3] : 3'b000)
                             | {~port_en[k], ~chb_en[k], ~cha_en[k]};

    always_ff @(posedge clk) begin
      if (!rst_n)   en_q[3*k +: 3] <= 3'b000;
      else if (sel) en_q[3*k +: 3] <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      irq      <= 1'b0;
    end else begin
      sticky_q <= evt_vec | (sticky_q & ~clr_vec);
      irq      <= |(sticky_q & en_q);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NPORT; k++)
      if (rd_addr == ADDR_W'(k)) rd_data[5:0] = {sticky_q[3*k +: 3], en_q[3*k +: 3]};
    if (rd_addr == ADDR_W'(NPORT)) rd_data[NB-1:0] = sticky_q & en_q;
  end
endmodule

module sport_err_hub_chk #(
  parameter int NPORT  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [NPORT-1:0]  port_en,
  input logic [NPORT-1:0]  cha_en,
  input logic [NPORT-1:0]  chb_en,
  input logic [NPORT-1:0]  derr_a_pls,
  input logic [NPORT-1:0]  derr_b_pls,
  input logic [NPORT-1:0]  fserr_pls,
  input logic [NPORT-1:0]  late_fs_mode,
  input logic [NPORT-1:0]  xfer_busy,
  input logic [NPORT-1:0]  fs_level,
  input logic              irq,
  input logic [3*NPORT-1:0] sticky_q,
  input logic [3*NPORT-1:0] en_q
);
  localparam int NB = 3 * NPORT;
  logic [NB-1:0] evt_m, late_m, w1c_m, dis_m, clr_m;

  for (genvar k = 0; k < NPORT; k++) begin : g_m
    assign late_m[3*k +: 3] = {late_fs_mode[k] & xfer_busy[k] & ~fs_level[k], 2'b00};
    assign evt_m[3*k +: 3]  = {fserr_pls[k], derr_b_pls[k], derr_a_pls[k]} | late_m[3*k +: 3];
    assign w1c_m[3*k +: 3]  = (wr_en && wr_addr == ADDR_W'(k)) ? wr_data[5:3] : 3'b000;
    assign dis_m[3*k +: 3]  = {~port_en[k], ~chb_en[k], ~cha_en[k]};
  end
  assign clr_m = w1c_m | dis_m;

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_m != '0) |=> ((sticky_q & $past(evt_m)) == $past(evt_m)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sticky_q & $past(sticky_q) & ~$past(clr_m)) == '0));
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_m != '0) |=> ((sticky_q & $past(w1c_m) & ~$past(evt_m)) == '0));
  p_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_m != '0) |=> ((sticky_q & $past(dis_m) & ~$past(evt_m)) == '0));
  p_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_m & clr_m) != '0) |=> ((sticky_q & $past(evt_m & clr_m)) == $past(evt_m & clr_m)));
  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(sticky_q & en_q)));
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|(sticky_q & en_q)) |=> !irq);
  p_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(NPORT)) |-> ((rd_data[NB-1:0] & ~(sticky_q & en_q)) == '0));
  p_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (late_m != '0) |=> ((sticky_q & $past(late_m)) == $past(late_m)));
endmodule

bind sport_err_hub sport_err_hub_chk #(.NPORT(NPORT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sport_err_hub_bench.sv
module sport_err_hub_bench;
  localparam int NPORT = 4, DATA_W = 32, ADDR_W = $clog2(NPORT + 1);

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NPORT-1:0] port_en = '1, cha_en = '1, chb_en = '1;
  logic [NPORT-1:0] derr_a_pls = '0, derr_b_pls = '0, fserr_pls = '0;
  logic [NPORT-1:0] late_fs_mode = '0, xfer_busy = '0, fs_level = '0;
  logic irq;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R9";

  logic [2:0] m_st [NPORT];
  logic [2:0] m_en [NPORT];
  bit m_irq;

  always #10 clk = ~clk;

  sport_err_hub #(.NPORT(NPORT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sport_err_hub (.*);

  always @(posedge clk) begin
    bit any;
    any = 0;
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++) begin m_st[p] = 0; m_en[p] = 0; end
      m_irq = 0;
    end else begin
      for (int p = 0; p < NPORT; p++) if ((m_st[p] & m_en[p]) != 0) any = 1;
      for (int p = 0; p < NPORT; p++) begin
        logic [2:0] ev, cl;
        bit hit;
        hit = wr_en && (int'(wr_addr) == p);
        ev = {fserr_pls[p] | (late_fs_mode[p] & xfer_busy[p] & ~fs_level[p]),
              derr_b_pls[p], derr_a_pls[p]};
        cl = (hit ? wr_data[5:3] : 3'b0) | {~port_en[p], ~chb_en[p], ~cha_en[p]};
        m_st[p] = ev | (m_st[p] & ~cl);
        if (hit) m_en[p] = wr_data[2:0];
      end
      m_irq = any;
    end
  end

  function automatic logic [DATA_W-1:0] exp_rd(int a);
    logic [DATA_W-1:0] v;
    v = '0;
    if (a < NPORT) v[5:0] = {m_st[a], m_en[a]};
    else if (a == NPORT)
      for (int p = 0; p < NPORT; p++) v[3*p +: 3] = m_st[p] & m_en[p];
    return v;
  endfunction

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk(DATA_W'(irq), DATA_W'(m_irq), {cur_req, " irq"});
      chk(rd_data, exp_rd(int'(rd_addr)), {cur_req, " rd_data"});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic nxt(); @(negedge clk); endtask

  task automatic rd_chk(input int a, input logic [DATA_W-1:0] exp, input string tag);
    rd_addr = ADDR_W'(a);
    #1;
    chk(rd_data, exp, tag);
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = d;
    nxt();
    wr_en = 0;
  endtask

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    nxt();
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R9 reset read");
    chk(DATA_W'(irq), 0, "R9 reset irq");

    cur_req = "R1";
    derr_a_pls[1] = 1; nxt(); derr_a_pls[1] = 0; nxt();
    rd_chk(1, 8, "R1 chan A port1");
    fserr_pls[2] = 1; nxt(); fserr_pls[2] = 0; nxt();
    rd_chk(2, 32, "R1 fsync port2");
    rd_chk(1, 8, "R2 still set");

    cur_req = "R3";
    wr(1, 0); rd_chk(1, 8, "R3 write zero no effect");
    wr(1, 8); rd_chk(1, 0, "R3 w1c clears");
    wr(2, 4); rd_chk(2, 36, "R3 enable write");

    cur_req = "R6";
    nxt();
    chk(DATA_W'(irq), 1, "R6 irq high");
    wr(2, 6'b100_100);
    chk(DATA_W'(irq), 1, "R6 irq lags one cycle");
    nxt();
    chk(DATA_W'(irq), 0, "R6 irq low");
    derr_b_pls[0] = 1; nxt(); derr_b_pls[0] = 0; nxt(); nxt();
    chk(DATA_W'(irq), 0, "R6 disabled error no irq");
    wr(0, 6'b010_000);

    cur_req = "R4";
    derr_a_pls[3] = 1; derr_b_pls[3] = 1; fserr_pls[3] = 1; nxt();
    derr_a_pls[3] = 0; derr_b_pls[3] = 0; fserr_pls[3] = 0; nxt();
    rd_chk(3, 56, "R4 all set");
    cha_en[3] = 0; nxt(); cha_en[3] = 1; nxt();
    rd_chk(3, 48, "R4 cha disable");
    port_en[3] = 0; nxt(); port_en[3] = 1; nxt();
    rd_chk(3, 16, "R4 port disable");
    chb_en[3] = 0; nxt(); chb_en[3] = 1; nxt();
    rd_chk(3, 0, "R4 chb disable");

    cur_req = "R5";
    derr_a_pls[0] = 1; wr_en = 1; wr_addr = 0; wr_data = 6'b001_000; nxt();
    derr_a_pls[0] = 0; wr_en = 0; nxt();
    rd_chk(0, 8, "R5 set beats w1c");
    wr(0, 8);
    derr_a_pls[0] = 1; cha_en[0] = 0; nxt();
    derr_a_pls[0] = 0; cha_en[0] = 1; nxt();
    rd_chk(0, 8, "R5 set beats disable");

    cur_req = "R7";
    wr(0, 7); nxt();
    rd_chk(0, 15, "R7 port0 reg");
    rd_chk(NPORT, 1, "R7 summary");
    wr(NPORT, '1); nxt();
    rd_chk(NPORT, 1, "R7 summary write ignored");
    rd_chk(0, 15, "R7 port0 after summary write");
    rd_chk(7, 0, "R7 unmapped");
    wr(0, 6'b111_000);

    cur_req = "R8";
    xfer_busy[1] = 1; fs_level[1] = 0; nxt(); nxt();
    rd_chk(1, 0, "R8 mode off no effect");
    late_fs_mode[1] = 1; fs_level[1] = 1; nxt(); nxt(); nxt();
    rd_chk(1, 0, "R8 held fsync ok");
    fs_level[1] = 0; nxt(); fs_level[1] = 1; xfer_busy[1] = 0; nxt();
    rd_chk(1, 32, "R8 late fsync drop");
    late_fs_mode[1] = 0;

    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      derr_a_pls = NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom);
      derr_b_pls = NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom);
      fserr_pls  = NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom);
      port_en = ~(NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom));
      cha_en  = ~(NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom));
      chb_en  = ~(NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom) & NPORT'($urandom));
      late_fs_mode = NPORT'($urandom); xfer_busy = NPORT'($urandom);
      fs_level = NPORT'($urandom) | NPORT'($urandom);
      wr_en = ($urandom % 6) == 0;
      wr_addr = ADDR_W'($urandom % 8);
      wr_data = $urandom;
      rd_addr = ADDR_W'($urandom % 8);
      nxt();
    end
    wr_en = 0;
    nxt(); nxt();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule